// File: doc/BRIEF.md
# Dual Preload Counter Controller

This block decides when a counter is parallel-loaded and which of two preload values it takes. Six conditions can start a load: a software request, the channel moving from halted to running, the zero-count flag, the compare-match flag, the Index input entering its active level, and the Index input staying at its active level. Each hardware condition has its own enable bit. A software request is always honoured. When a load fires, a one-cycle strobe goes high, the chosen preload value is driven out, and the counter takes that value at the next clock edge.

A mode bit picks how the two preload registers are used. With the bit clear, only the first register is used. With the bit set, the active register alternates after every load event. Starting the channel always makes the first register active. An 8-bit up/down counter is built in so that every load can be seen on a port. The zero and match flags come from outside; quadrature decoding and the comparator are not part of the block.

Top module: `dual_preload_counter`

## Requirements
- R1: `trigEn` enables each hardware trigger: bit 0 halted-to-running, bit 1 zero flag, bit 2 match flag, bit 3 Index entering its active level, bit 4 Index held at its active level. A hardware condition whose enable bit is 0 never raises `loadStb`.
- R2: `softLoad` raises `loadStb` in the same cycle whether the channel is running or halted. While `runEn` is 0, hardware triggers have no effect.
- R3: When `bothMode` is 0, every load drives `preload0` on `loadVal`, and `selState` stays 0 from reset.
- R4: When `bothMode` is 1, a load drives `preload0` if `selState` is 0 and `preload1` if `selState` is 1. After the load, `selState` flips.
- R5: In the first cycle that `runEn` is 1 after being 0, the active register is forced to the first one. If that cycle loads, `loadVal` is `preload0`, and the next `selState` is 1 when `bothMode` is 1 and 0 when it is 0. If that cycle does not load, the next `selState` is 0.
- R6: A load takes priority over counting. The cycle after `loadStb`, `count` equals the `loadVal` that was driven.
- R7: When several triggers fire in one cycle, they cause a single load and at most one flip of `selState`.
- R8: Index is active when `idxIn` equals `idxPol` (1 means active high). With bit 4 enabled, the counter reloads on every running cycle while Index is active. `selState` flips only on the cycle that Index enters its active level.
- R9: When running and not loading, `cntUp` alone adds 1 and `cntDn` alone subtracts 1, both wrapping modulo 2^CNT_W. Both together, or neither, hold the count. When halted with no soft load, the count holds.
- R10: After reset, `count` is 0 and `selState` is 0. With the channel halted and no soft request, `loadStb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| preload0 | input | CNT_W | First preload value |
| preload1 | input | CNT_W | Second preload value |
| bothMode | input | 1 | 1 = alternate between both registers |
| trigEn | input | 5 | Hardware trigger enables (see R1) |
| softLoad | input | 1 | Software preload request |
| runEn | input | 1 | 1 = channel running, 0 = halted |
| zeroFlag | input | 1 | Counter reached zero |
| matchFlag | input | 1 | Compare match |
| idxIn | input | 1 | Index input |
| idxPol | input | 1 | Active level of Index |
| cntUp | input | 1 | Count-up request |
| cntDn | input | 1 | Count-down request |
| loadStb | output | 1 | Load happens at the next edge |
| loadVal | output | CNT_W | Value being loaded |
| selState | output | 1 | Active preload register (0 = first, 1 = second) |
| count | output | CNT_W | Counter value |

## Verification
The bench goes after these corner cases:
- A run-start that coincides with another trigger. A design that toggled from the old selector would load `preload1` where `preload0` is required.
- Soft, zero and match requests in one cycle. A design that counted each request would end up with the selector flipped the wrong number of times.
- A held active-low Index. A design that toggled on level would make the loaded value alternate every clock instead of staying put.
- Hardware flags asserted while halted. These must leave the count unchanged, while a soft request in the same state must still load.

A sweep covers all 32 enable masks in both modes under pseudo-random stimulus. Each cycle is compared against a model that the bench builds from the requirements.

// File: rtl/pl_pkg.sv
package pl_pkg;
  localparam int TRG_RUN   = 0;
  localparam int TRG_ZERO  = 1;
  localparam int TRG_MATCH = 2;
  localparam int TRG_IEDGE = 3;
  localparam int TRG_ILVL  = 4;
  localparam int TRG_NUM   = 5;

  typedef struct packed {
    logic load;
    logic usePre1;
    logic incr;
    logic decr;
  } plStrobe_t;
endpackage

// File: rtl/pl_ctrl.sv
module pl_ctrl
  import pl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               bothMode,
  input  logic [TRG_NUM-1:0] trigEn,
  input  logic               softLoad,
  input  logic               runEn,
  input  logic               zeroFlag,
  input  logic               matchFlag,
  input  logic               idxIn,
  input  logic               idxPol,
  input  logic               cntUp,
  input  logic               cntDn,
  output plStrobe_t          stb,
  output logic               selState
);
  logic               runPrev, idxPrev, selQ;
  logic               idxAct, idxEnter, runRise;
  logic [TRG_NUM-1:0] rawTrig, flipTrig;
  logic               hwLoad, hwFlip, loadNow, flipNow, effSel, selNext;

  assign idxAct   = (idxIn == idxPol);
  assign idxEnter = idxAct & ~idxPrev;
  assign runRise  = runEn & ~runPrev;

  // Conditions per trigger slot; the level slot loads every cycle but
  // only flips the selector on entry to the active level.
  always_comb begin
    rawTrig            = '0;
    rawTrig[TRG_RUN]   = runRise;
    rawTrig[TRG_ZERO]  = zeroFlag;
    rawTrig[TRG_MATCH] = matchFlag;
    rawTrig[TRG_IEDGE] = idxEnter;
    rawTrig[TRG_ILVL]  = idxAct;
    flipTrig           = rawTrig;
    flipTrig[TRG_ILVL] = idxEnter;
  end

  assign hwLoad  = runEn & |(rawTrig & trigEn);
  assign hwFlip  = runEn & |(flipTrig & trigEn);
  assign loadNow = softLoad | hwLoad;
  assign flipNow = softLoad | hwFlip;
  assign effSel  = runRise ? 1'b0 : selQ;
  assign selNext = (loadNow & flipNow & bothMode) ? ~effSel : effSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runPrev <= 1'b0;
      idxPrev <= 1'b1;
      selQ    <= 1'b0;
    end else begin
      runPrev <= runEn;
      idxPrev <= idxAct;
      selQ    <= selNext;
    end
  end

  always_comb begin
    stb.load    = loadNow;
    stb.usePre1 = bothMode & effSel;
    stb.incr    = ~loadNow & runEn & cntUp & ~cntDn;
    stb.decr    = ~loadNow & runEn & cntDn & ~cntUp;
  end

  assign selState = selQ;
endmodule

// File: rtl/pl_datapath.sv
module pl_datapath
  import pl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  plStrobe_t        stb,
  input  logic [CNT_W-1:0] preload0,
  input  logic [CNT_W-1:0] preload1,
  output logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;

  assign loadVal = stb.usePre1 ? preload1 : preload0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cntQ <= '0;
    else if (stb.load)  cntQ <= loadVal;
    else if (stb.incr)  cntQ <= cntQ + ONE;
    else if (stb.decr)  cntQ <= cntQ - ONE;
  end

  assign count = cntQ;
endmodule

// File: rtl/dual_preload_counter.sv
module dual_preload_counter
  import pl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   preload0,
  input  logic [CNT_W-1:0]   preload1,
  input  logic               bothMode,
  input  logic [TRG_NUM-1:0] trigEn,
  input  logic               softLoad,
  input  logic               runEn,
  input  logic               zeroFlag,
  input  logic               matchFlag,
  input  logic               idxIn,
  input  logic               idxPol,
  input  logic               cntUp,
  input  logic               cntDn,
  output logic               loadStb,
  output logic [CNT_W-1:0]   loadVal,
  output logic               selState,
  output logic [CNT_W-1:0]   count
);
  plStrobe_t stb;

  pl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bothMode(bothMode), .trigEn(trigEn),
    .softLoad(softLoad), .runEn(runEn), .zeroFlag(zeroFlag),
    .matchFlag(matchFlag), .idxIn(idxIn), .idxPol(idxPol),
    .cntUp(cntUp), .cntDn(cntDn), .stb(stb), .selState(selState)
  );

  pl_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .preload0(preload0),
    .preload1(preload1), .loadVal(loadVal), .count(count)
  );

  assign loadStb = stb.load;
endmodule

// File: rtl/dual_preload_counter_chk.sv
module dual_preload_counter_chk
  import pl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [CNT_W-1:0]   preload0,
  input logic [CNT_W-1:0]   preload1,
  input logic               bothMode,
  input logic [TRG_NUM-1:0] trigEn,
  input logic               softLoad,
  input logic               runEn,
  input logic               cntUp,
  input logic               cntDn,
  input logic               loadStb,
  input logic [CNT_W-1:0]   loadVal,
  input logic               selState,
  input logic [CNT_W-1:0]   count
);
  a_r1_disabled_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (trigEn == '0 && !softLoad) |-> !loadStb);

  a_r2_halted_no_hw: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !softLoad) |-> !loadStb);

  a_r3_single_uses_first: assert property (@(posedge clk) disable iff (!rstN)
    (!bothMode && loadStb) |-> loadVal == preload0);

  a_r4_second_when_active: assert property (@(posedge clk) disable iff (!rstN)
    (bothMode && selState && loadStb && !$rose(runEn)) |-> loadVal == preload1);

  a_r5_start_uses_first: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(runEn) && loadStb) |-> loadVal == preload0);

  a_r6_load_lands: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> count == $past(loadVal));

  a_r9_count_up: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !loadStb && cntUp && !cntDn) |=> count == CNT_W'($past(count) + 1'b1));

  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !softLoad) |=> count == $past(count));
endmodule

bind dual_preload_counter dual_preload_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .preload0(preload0), .preload1(preload1),
  .bothMode(bothMode), .trigEn(trigEn), .softLoad(softLoad), .runEn(runEn),
  .cntUp(cntUp), .cntDn(cntDn), .loadStb(loadStb), .loadVal(loadVal),
  .selState(selState), .count(count)
);

// File: tb/dual_preload_counter_tb_top.sv
module dual_preload_counter_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] preload0 = 8'h40, preload1 = 8'h90;
  logic bothMode = 1'b0;
  logic [4:0] trigEn = '0;
  logic softLoad = 0, runEn = 0, zeroFlag = 0, matchFlag = 0;
  logic idxIn = 0, idxPol = 1, cntUp = 0, cntDn = 0;
  logic loadStb, selState;
  logic [W-1:0] loadVal, count;

  int nChecks = 0;
  int nErr = 0;

  // reference state
  logic mRunPrev, mIdxPrev, mSel;
  logic [W-1:0] mCnt;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  dual_preload_counter #(.CNT_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .preload0(preload0), .preload1(preload1),
    .bothMode(bothMode), .trigEn(trigEn), .softLoad(softLoad), .runEn(runEn),
    .zeroFlag(zeroFlag), .matchFlag(matchFlag), .idxIn(idxIn), .idxPol(idxPol),
    .cntUp(cntUp), .cntDn(cntDn), .loadStb(loadStb), .loadVal(loadVal),
    .selState(selState), .count(count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mRunPrev = 1'b0; mIdxPrev = 1'b1; mSel = 1'b0; mCnt = '0;
  endtask

  // One cycle: inputs already set at a falling edge.
  task automatic cyc(input string tag);
    logic act, enter, rise, hw, flip, ld, eff, nSel;
    logic [W-1:0] val;
    #1;
    act   = (idxIn == idxPol);
    enter = act & ~mIdxPrev;
    rise  = runEn & ~mRunPrev;
    hw    = runEn & ((rise & trigEn[0]) | (zeroFlag & trigEn[1]) |
                     (matchFlag & trigEn[2]) | (enter & trigEn[3]) | (act & trigEn[4]));
    flip  = softLoad | (runEn & ((rise & trigEn[0]) | (zeroFlag & trigEn[1]) |
                     (matchFlag & trigEn[2]) | (enter & (trigEn[3] | trigEn[4]))));
    ld    = softLoad | hw;
    eff   = rise ? 1'b0 : mSel;
    val   = (bothMode & eff) ? preload1 : preload0;
    nSel  = (ld & flip & bothMode) ? ~eff : eff;
    chk(loadStb === ld, {tag, " strobe"}, int'(loadStb), int'(ld));
    if (ld) chk(loadVal === val, {tag, " value"}, int'(loadVal), int'(val));
    mRunPrev = runEn; mIdxPrev = act; mSel = nSel;
    if (ld) mCnt = val;
    else if (runEn && cntUp && !cntDn) mCnt = mCnt + 1'b1;
    else if (runEn && cntDn && !cntUp) mCnt = mCnt - 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(count === mCnt, {tag, " count"}, int'(count), int'(mCnt));
    chk(selState === mSel, {tag, " selector"}, int'(selState), int'(mSel));
  endtask

  task automatic idle();
    softLoad = 0; zeroFlag = 0; matchFlag = 0; cntUp = 0; cntDn = 0;
  endtask

  initial begin
    #2_000_000;
    nErr++; nChecks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    #1;
    // R10 reset state
    chk(count == 0, "R10 count", int'(count), 0);
    chk(selState == 0, "R10 selector", int'(selState), 0);
    chk(loadStb == 0, "R10 strobe", int'(loadStb), 0);

    // R9 counting
    runEn = 1; trigEn = '0;
    cntUp = 1; repeat (3) cyc("R9");
    chk(count == 3, "R9 up", int'(count), 3);
    cntUp = 0; cntDn = 1; repeat (4) cyc("R9");
    chk(count == 8'hFF, "R9 wrap", int'(count), 255);
    cntUp = 1; cyc("R9");
    chk(count == 8'hFF, "R9 both hold", int'(count), 255);
    idle();

    // R1 disabled triggers
    zeroFlag = 1; matchFlag = 1; cyc("R1");
    chk(count == 8'hFF, "R1 no load", int'(count), 255);
    idle();

    // R3 single-register mode
    bothMode = 0;
    repeat (3) begin softLoad = 1; cyc("R3"); chk(count == 8'h40, "R3 value", int'(count), 64); end
    idle();

    // R4 alternating
    bothMode = 1;
    softLoad = 1; cyc("R4"); chk(count == 8'h40, "R4 first", int'(count), 64);
    cyc("R4"); chk(count == 8'h90, "R4 second", int'(count), 144);
    cyc("R4"); chk(count == 8'h40, "R4 third", int'(count), 64);
    idle();

    // R7 simultaneous triggers
    trigEn = 5'b00110; softLoad = 1; zeroFlag = 1; matchFlag = 1;
    cyc("R7");
    chk(selState == 0, "R7 single flip", int'(selState), 0);
    idle();

    // R2 halted behaviour
    runEn = 0; trigEn = 5'b11111; zeroFlag = 1; matchFlag = 1; cntUp = 1;
    cyc("R2"); cyc("R2");
    chk(count == 8'h90, "R2 hold", int'(count), 144);
    idle(); softLoad = 1; cyc("R2");
    chk(count == 8'h40, "R2 soft while halted", int'(count), 64);
    idle();

    // R5 run start
    trigEn = 5'b00001; runEn = 1; cyc("R5");
    chk(count == 8'h40, "R5 first reg", int'(count), 64);
    chk(selState == 1, "R5 selector", int'(selState), 1);
    cyc("R5");

    // R8 level Index, active low
    trigEn = 5'b10000; idxPol = 0; idxIn = 1; cntUp = 1; cyc("R8");
    idxIn = 0; repeat (4) cyc("R8");
    chk(count == 8'h40, "R8 held", int'(count), 64);
    idxIn = 1; cyc("R8"); idxPol = 1; idxIn = 0;
    idle();

    // R6 load beats counting
    softLoad = 1; cntUp = 1; cyc("R6");
    idle();

    // sweep
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 32; e++) begin
        bothMode = m[0]; trigEn = e[4:0];
        for (int k = 0; k < 40; k++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          softLoad = lfsr[0] & lfsr[5] & lfsr[9];
          runEn = ~(lfsr[1] & lfsr[2] & lfsr[3]);
          zeroFlag = lfsr[4] & lfsr[6];
          matchFlag = lfsr[7] & lfsr[8];
          idxIn = lfsr[10] ^ lfsr[1];
          idxPol = lfsr[15] & lfsr[14] & lfsr[13] ? ~idxPol : idxPol;
          cntUp = lfsr[11]; cntDn = lfsr[12];
          if (k % 13 == 0) begin preload0 = lfsr[7:0]; preload1 = lfsr[15:8]; end
          cyc("R1 sweep");
        end
      end
    end

    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule